// File: doc/BRIEF.md
# Software-Loaded Translation Buffer Lookup

This block resolves one memory access against a small set-associative translation buffer whose entries are written by software. The buffer is split into two halves, one used only by instruction fetches and one used only by loads and stores. Each entry holds a tag page number and two 32-bit page-table words. The first word carries a valid flag, a hash-select flag and a virtual tag. The second word carries the real page number, cache attributes, the referenced and changed flags, and a 2-bit protection code.

A request gives an effective address, an access kind, a key bit, a no-execute bit and the expected tag word. The block searches every way of the selected set in way order. It reports a hit that grants the access, a hit that breaks protection, or a miss. With the status it returns the second page-table word of the chosen entry and the read/write/execute rights that result. On any hit the block writes the referenced flag back into the chosen entry one cycle later, and also the changed flag when a store is granted. A fill port lets software write a complete entry at a flat index. Walking a page table in memory is left to the software that fills the buffer.

Top module: `swtlb_lookup`

## Requirements
- R1: The set is address bits [PAGE_BITS+SET_W-1:PAGE_BITS]. The flat entry index is side*WAYS*SETS + way*SETS + set, with side 1 for fetches (req_type 2) and side 0 for loads (0) and stores (1). This index is also the fill index, so a fetch never sees a data entry and a load never sees an instruction entry.
- R2: An entry is a candidate only if its stored page number equals the address bits above PAGE_BITS, bit 31 of its first word (valid) is 1, and bit 6 of its first word (hash select) is 0.
- R3: A candidate hits only if (first word AND 0x7FFFFFBF) equals req_match.
- R4: Rights depend on the key and the code in bits [1:0] of the second word. With key 0, codes 0, 1 and 2 give read and write, and code 3 gives read only. With key 1, code 0 gives nothing, codes 1 and 3 give read only, and code 2 gives read and write. Execute is given whenever req_nx is 0. The rights are reported as rsp_perm {exec, write, read}. A load needs read, a store needs write and a fetch needs execute.
- R5: Ways are scanned from way 0 upward. The first hit that grants the access is chosen and the scan stops there. A hit that breaks protection becomes the chosen entry, but the scan goes on and a later consistent hit replaces it.
- R6: A hit whose second word differs from the currently chosen entry in the bits under mask 0xFFFFF07B is ignored.
- R7: After any hit, the chosen entry's second word has bit 8 (referenced) set and all bits except 8 and 7 unchanged. rsp_pte1 returns the word as it was before this update. A miss returns 0.
- R8: If bit 7 (changed) of the chosen word is 0, a granted store sets it. Any other access clears write in rsp_perm.
- R9: rsp_valid pulses one cycle after an accepted request. rsp_status is 0 for a miss, 1 for granted and 2 for a protection violation. busy is 1 for exactly the next cycle after a hit, and a request made while busy is 1 gets no response.
- R10: When fill_en and req_valid are both high in a cycle, the fill is written and the request gets no response.
- R11: After reset the outputs are 0 and every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Write one entry |
| fill_idx | input | IDX_W | Flat entry index to write |
| fill_epn | input | ADDR_W-PAGE_BITS | Tag page number for the filled entry |
| fill_pte0 | input | 32 | First page-table word |
| fill_pte1 | input | 32 | Second page-table word |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Effective address |
| req_type | input | 2 | 0 load, 1 store, 2 fetch |
| req_key | input | 1 | Access key |
| req_nx | input | 1 | No-execute for the segment |
| req_match | input | 32 | Expected masked tag word |
| busy | output | 1 | Flag write-back in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 miss, 1 granted, 2 violation |
| rsp_perm | output | 3 | {exec, write, read} |
| rsp_pte1 | output | 32 | Chosen second word before update |

## Verification
The bench builds the block with two ways and four sets per way on each side, which gives sixteen entries. At that size it can fill and look up every slot on both sides and sweep every combination of key, protection code, no-execute bit and access kind. Two-way sets are enough for all the ordering cases: a granting way 0, two violating ways, a later hit that disagrees, and a way 0 that fails as a candidate. A model in the bench tracks the referenced and changed flags across repeated accesses to the same page.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
  localparam int PTE_W = 32;
  localparam logic [PTE_W-1:0] P0_VALID      = 32'h8000_0000;
  localparam int               P0_HSEL_BIT   = 6;
  localparam logic [PTE_W-1:0] P0_TAG_MASK   = 32'h7FFF_FFBF;
  localparam logic [PTE_W-1:0] P1_AGREE_MASK = 32'hFFFF_F07B;
  localparam logic [PTE_W-1:0] P1_REF        = 32'h0000_0100;
  localparam logic [PTE_W-1:0] P1_CHG        = 32'h0000_0080;

  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {ST_MISS = 2'd0, ST_GRANT = 2'd1, ST_VIOL = 2'd2} stat_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic perm_t pp_rights(input logic key, input logic [1:0] pp, input logic nx);
    perm_t p;
    p.x = !nx;
    case ({key, pp})
      3'b011:                 {p.w, p.r} = 2'b01;
      3'b100:                 {p.w, p.r} = 2'b00;
      3'b101, 3'b111:         {p.w, p.r} = 2'b01;
      default:                {p.w, p.r} = 2'b11;
    endcase
    return p;
  endfunction

  function automatic logic perm_ok(input perm_t p, input logic [1:0] acc);
    case (acc)
      ACC_STORE: return p.w;
      ACC_FETCH: return p.x;
      default:   return p.r;
    endcase
  endfunction
endpackage

// File: rtl/swtlb_store.sv
module swtlb_store
  import swtlb_pkg::*;
#(
  parameter int EPN_W = 20,
  parameter int WAYS  = 2,
  parameter int SETS  = 32,
  localparam int SET_W   = $clog2(SETS),
  localparam int ENTRIES = 2 * WAYS * SETS,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fill_en,
  input  logic [IDX_W-1:0]                 fill_idx,
  input  logic [EPN_W-1:0]                 fill_epn,
  input  logic [PTE_W-1:0]                 fill_pte0,
  input  logic [PTE_W-1:0]                 fill_pte1,
  input  logic                             wb_en,
  input  logic [IDX_W-1:0]                 wb_idx,
  input  logic [PTE_W-1:0]                 wb_pte1,
  input  logic                             rd_side,
  input  logic [SET_W-1:0]                 rd_set,
  output logic [WAYS-1:0][EPN_W-1:0]       rd_epn,
  output logic [WAYS-1:0][PTE_W-1:0]       rd_pte0,
  output logic [WAYS-1:0][PTE_W-1:0]       rd_pte1
);
  logic [EPN_W-1:0] epn_q [ENTRIES];
  logic [PTE_W-1:0] p0_q  [ENTRIES];
  logic [PTE_W-1:0] p1_q  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        epn_q[e] <= '0;
        p0_q[e]  <= '0;
        p1_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (fill_en && fill_idx == IDX_W'(e)) begin
          epn_q[e] <= fill_epn;
          p0_q[e]  <= fill_pte0;
          p1_q[e]  <= fill_pte1;
        end else if (wb_en && wb_idx == IDX_W'(e)) begin
          p1_q[e]  <= wb_pte1;
        end
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      logic [IDX_W-1:0] ri;
      ri = IDX_W'(int'(rd_side) * WAYS * SETS + w * SETS + int'(rd_set));
      rd_epn[w]  = epn_q[ri];
      rd_pte0[w] = p0_q[ri];
      rd_pte1[w] = p1_q[ri];
    end
  end

  AST_WB_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (((wb_pte1 ^ p1_q[wb_idx]) & ~(P1_REF | P1_CHG)) == '0)); // R7
  AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> ((p1_q[$past(wb_idx)] & P1_REF) != '0) || $past(fill_en)); // R7
endmodule

// File: rtl/swtlb_way_cmp.sv
module swtlb_way_cmp
  import swtlb_pkg::*;
#(
  parameter int EPN_W = 20
) (
  input  logic [EPN_W-1:0] ent_epn,
  input  logic [PTE_W-1:0] ent_pte0,
  input  logic [1:0]       ent_pp,
  input  logic [EPN_W-1:0] req_epn,
  input  logic [PTE_W-1:0] req_match,
  input  logic             req_key,
  input  logic             req_nx,
  input  logic [1:0]       req_acc,
  output logic             hit,
  output logic             grant,
  output perm_t            perm
);
  always_comb begin
    hit   = (ent_epn == req_epn) && ((ent_pte0 & P0_VALID) != '0) &&
            !ent_pte0[P0_HSEL_BIT] && ((ent_pte0 & P0_TAG_MASK) == req_match);
    perm  = pp_rights(req_key, ent_pp, req_nx);
    grant = hit && perm_ok(perm, req_acc);
  end
endmodule

// File: rtl/swtlb_pick.sv
module swtlb_pick
  import swtlb_pkg::*;
#(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0]            way_hit,
  input  logic [WAYS-1:0]            way_grant,
  input  perm_t [WAYS-1:0]           way_perm,
  input  logic [WAYS-1:0][PTE_W-1:0] way_pte1,
  input  logic                       is_store,
  output logic                       found,
  output logic                       granted,
  output logic [WAY_W-1:0]           best_way,
  output logic [PTE_W-1:0]           best_pte1,
  output logic [PTE_W-1:0]           wb_pte1,
  output perm_t                      perm_out
);
  perm_t best_perm;

  always_comb begin
    found     = 1'b0;
    granted   = 1'b0;
    best_way  = '0;
    best_pte1 = '0;
    best_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!granted && way_hit[w]) begin
        if (!found || (((way_pte1[w] ^ best_pte1) & P1_AGREE_MASK) == '0)) begin
          found     = 1'b1;
          best_way  = WAY_W'(w);
          best_pte1 = way_pte1[w];
          best_perm = way_perm[w];
          if (way_grant[w]) granted = 1'b1;
        end
      end
    end
    perm_out = best_perm;
    if (((best_pte1 & P1_CHG) == '0) && !(granted && is_store)) perm_out.w = 1'b0;
    wb_pte1 = best_pte1 | P1_REF | ((granted && is_store) ? P1_CHG : '0);
  end

  AST_BEST_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> way_hit[best_way]); // R5
  AST_GRANT_FROM_BEST: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> (way_grant[best_way] && found)); // R5
endmodule

// File: rtl/swtlb_lookup.sv
module swtlb_lookup
  import swtlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int WAYS      = 2,
  parameter int SETS      = 32,
  localparam int EPN_W   = ADDR_W - PAGE_BITS,
  localparam int SET_W   = $clog2(SETS),
  localparam int IDX_W   = $clog2(2 * WAYS * SETS),
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [EPN_W-1:0]  fill_epn,
  input  logic [31:0]       fill_pte0,
  input  logic [31:0]       fill_pte1,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_type,
  input  logic              req_key,
  input  logic              req_nx,
  input  logic [31:0]       req_match,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [2:0]        rsp_perm,
  output logic [31:0]       rsp_pte1
);
  logic [EPN_W-1:0]             req_epn;
  logic [SET_W-1:0]             rd_set;
  logic                         rd_side;
  logic [WAYS-1:0][EPN_W-1:0]   rd_epn;
  logic [WAYS-1:0][PTE_W-1:0]   rd_pte0, rd_pte1;
  logic [WAYS-1:0]              way_hit, way_grant;
  perm_t [WAYS-1:0]             way_perm;
  logic                         found, granted, accept;
  logic [WAY_W-1:0]             best_way;
  logic [PTE_W-1:0]             best_pte1, wb_word;
  perm_t                        sel_perm;

  logic             rsp_valid_q, rsp_valid_d;
  logic [1:0]       status_q, status_d;
  logic [2:0]       perm_q, perm_d;
  logic [31:0]      pte1_q, pte1_d;
  logic             wb_pend_q, wb_pend_d;
  logic [IDX_W-1:0] wb_idx_q, wb_idx_d;
  logic [31:0]      wb_pte1_q, wb_pte1_d;

  assign req_epn = req_addr[ADDR_W-1:PAGE_BITS];
  assign rd_set  = req_addr[PAGE_BITS +: SET_W];
  assign rd_side = (req_type == ACC_FETCH);

  swtlb_store #(.EPN_W(EPN_W), .WAYS(WAYS), .SETS(SETS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_epn(fill_epn),
    .fill_pte0(fill_pte0), .fill_pte1(fill_pte1),
    .wb_en(wb_pend_q), .wb_idx(wb_idx_q), .wb_pte1(wb_pte1_q),
    .rd_side(rd_side), .rd_set(rd_set),
    .rd_epn(rd_epn), .rd_pte0(rd_pte0), .rd_pte1(rd_pte1)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    swtlb_way_cmp #(.EPN_W(EPN_W)) u_cmp (
      .ent_epn(rd_epn[w]), .ent_pte0(rd_pte0[w]), .ent_pp(rd_pte1[w][1:0]),
      .req_epn(req_epn), .req_match(req_match), .req_key(req_key),
      .req_nx(req_nx), .req_acc(req_type),
      .hit(way_hit[w]), .grant(way_grant[w]), .perm(way_perm[w])
    );
  end

  swtlb_pick #(.WAYS(WAYS)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .way_hit(way_hit), .way_grant(way_grant), .way_perm(way_perm),
    .way_pte1(rd_pte1), .is_store(req_type == ACC_STORE),
    .found(found), .granted(granted), .best_way(best_way),
    .best_pte1(best_pte1), .wb_pte1(wb_word), .perm_out(sel_perm)
  );

  assign accept = req_valid && !fill_en && !wb_pend_q;

  always_comb begin
    rsp_valid_d = accept;
    status_d    = ST_MISS;
    perm_d      = '0;
    pte1_d      = '0;
    if (accept && found) begin
      status_d = granted ? ST_GRANT : ST_VIOL;
      perm_d   = sel_perm;
      pte1_d   = best_pte1;
    end
    wb_pend_d = accept && found;
    wb_idx_d  = IDX_W'(int'(rd_side) * WAYS * SETS + int'(best_way) * SETS + int'(rd_set));
    wb_pte1_d = wb_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      status_q    <= '0;
      perm_q      <= '0;
      pte1_q      <= '0;
      wb_pend_q   <= 1'b0;
      wb_idx_q    <= '0;
      wb_pte1_q   <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      status_q    <= status_d;
      perm_q      <= perm_d;
      pte1_q      <= pte1_d;
      wb_pend_q   <= wb_pend_d;
      if (accept) begin
        wb_idx_q  <= wb_idx_d;
        wb_pte1_q <= wb_pte1_d;
      end
    end
  end

  assign busy       = wb_pend_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = status_q;
  assign rsp_perm   = perm_q;
  assign rsp_pte1   = pte1_q;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R9
  AST_FILL_BLOCKS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !rsp_valid); // R10
  AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rsp_valid); // R9
  AST_MISS_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_MISS) |-> (rsp_perm == '0 && !busy)); // R9
  AST_HIT_HAS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != ST_MISS) |-> busy); // R7
endmodule

// File: tb/test_swtlb_lookup.sv
`timescale 1ns/1ps
module test_swtlb_lookup;
  localparam int ENT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_en = 1'b0;
  logic [3:0]  fill_idx = '0;
  logic [19:0] fill_epn = '0;
  logic [31:0] fill_pte0 = '0, fill_pte1 = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_type = '0;
  logic        req_key = 1'b0, req_nx = 1'b0;
  logic [31:0] req_match = '0;
  logic        busy, rsp_valid;
  logic [1:0]  rsp_status;
  logic [2:0]  rsp_perm;
  logic [31:0] rsp_pte1;

  always #10 clk = ~clk;

  swtlb_lookup #(.ADDR_W(32), .PAGE_BITS(12), .WAYS(2), .SETS(4)) i_swtlb_lookup (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_epn(fill_epn), .fill_pte0(fill_pte0), .fill_pte1(fill_pte1),
    .req_valid(req_valid), .req_addr(req_addr), .req_type(req_type),
    .req_key(req_key), .req_nx(req_nx), .req_match(req_match),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_perm(rsp_perm), .rsp_pte1(rsp_pte1)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [19:0] m_epn [ENT];
  logic [31:0] m_p0 [ENT];
  logic [31:0] m_p1 [ENT];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int slot(input int side, input int way, input int set);
    return side * 8 + way * 4 + set;
  endfunction

  function automatic logic [31:0] p0w(input logic [23:0] vsid, input logic [5:0] api);
    return {1'b1, vsid, 1'b0, api};
  endfunction

  function automatic logic [2:0] rights(input logic key, input logic [1:0] pp, input logic nx);
    logic r, w;
    r = !(key && pp == 2'd0);
    w = key ? (pp == 2'd2) : (pp != 2'd3);
    return {!nx, w, r};
  endfunction

  task automatic fill(input int side, input int way, input int set, input logic [19:0] epn,
                      input logic [31:0] p0, input logic [31:0] p1);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = 4'(slot(side, way, set));
    fill_epn = epn; fill_pte0 = p0; fill_pte1 = p1;
    @(negedge clk);
    fill_en = 1'b0;
    m_epn[slot(side, way, set)] = epn;
    m_p0[slot(side, way, set)]  = p0;
    m_p1[slot(side, way, set)]  = p1;
  endtask

  task automatic predict(input logic [31:0] addr, input logic [1:0] t, input logic key,
                         input logic nx, input logic [31:0] match,
                         output logic [1:0] st, output logic [2:0] perm, output logic [31:0] pte1);
    int side, set, bw;
    bit have, gr;
    logic [31:0] refw;
    logic [2:0] bp;
    side = (t == 2'd2) ? 1 : 0;
    set = int'(addr[13:12]);
    have = 0; gr = 0; refw = '0; bw = 0; bp = '0;
    for (int w = 0; w < 2; w++) begin
      int i;
      bit h;
      logic [2:0] p;
      bit need;
      i = slot(side, w, set);
      h = (m_epn[i] == addr[31:12]) && m_p0[i][31] && !m_p0[i][6] &&
          ((m_p0[i] & 32'h7FFF_FFBF) == match);
      if (h && !gr && (!have || ((m_p1[i] ^ refw) & 32'hFFFF_F07B) == '0)) begin
        have = 1; refw = m_p1[i]; bw = i;
        p = rights(key, m_p1[i][1:0], nx);
        bp = p;
        need = (t == 2'd1) ? p[1] : (t == 2'd2) ? p[2] : p[0];
        if (need) gr = 1;
      end
    end
    st = !have ? 2'd0 : gr ? 2'd1 : 2'd2;
    perm = '0; pte1 = '0;
    if (have) begin
      perm = bp;
      if (!refw[7] && !(gr && t == 2'd1)) perm[1] = 1'b0;
      pte1 = refw;
      m_p1[bw] = refw | 32'h100 | ((gr && t == 2'd1) ? 32'h80 : 32'h0);
    end
  endtask

  task automatic look(input logic [31:0] addr, input logic [1:0] t, input logic key,
                      input logic nx, input logic [31:0] match, input string req);
    logic [1:0] st;
    logic [2:0] perm;
    logic [31:0] pte1;
    predict(addr, t, key, nx, match, st, perm, pte1);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_type = t;
    req_key = key; req_nx = nx; req_match = match;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "status", 32'(rsp_status), 32'(st));
    chk(req, "perm", 32'(rsp_perm), 32'(perm));
    chk(req, "pte1", rsp_pte1, pte1);
    chk("R9", "busy", 32'(busy), 32'(st != 2'd0));
    @(negedge clk);
    chk("R9", "busy released", 32'(busy), 32'd0);
  endtask

  logic [31:0] mt;

  initial begin
    for (int i = 0; i < ENT; i++) begin m_epn[i] = '0; m_p0[i] = '0; m_p1[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11", "reset busy", 32'(busy), 32'd0);
    chk("R11", "reset status", 32'(rsp_status), 32'd0);
    chk("R11", "reset pte1", rsp_pte1, 32'd0);
    rst_n = 1'b1;
    look(32'h0000_0000, 2'd0, 1'b0, 1'b0, 32'h0, "R11");
    look(32'h0000_3000, 2'd2, 1'b0, 1'b0, 32'h0, "R11");

    // R1: every slot on both halves
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++)
        for (int st = 0; st < 4; st++) begin
          int i;
          logic [19:0] e;
          i = slot(s, w, st);
          e = 20'h00A00 | 20'(s << 5) | 20'(w << 4) | 20'(st);
          fill(s, w, st, e, p0w(24'h1000 + 24'(i), 6'(i)), (32'(32'h50 + i) << 12) | 32'h182);
        end
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++)
        for (int st = 0; st < 4; st++) begin
          int i;
          logic [19:0] e;
          i = slot(s, w, st);
          e = 20'h00A00 | 20'(s << 5) | 20'(w << 4) | 20'(st);
          mt = p0w(24'h1000 + 24'(i), 6'(i)) & 32'h7FFF_FFBF;
          look({e, 12'h000}, s ? 2'd2 : 2'd0, 1'b0, 1'b0, mt, "R1");
          if (s == 0) look({e, 12'h000}, 2'd2, 1'b0, 1'b0, mt, "R1");
        end

    // R4: key x code x nx x kind
    mt = p0w(24'h2222, 6'h11) & 32'h7FFF_FFBF;
    for (int t = 0; t < 3; t++)
      for (int k = 0; k < 2; k++)
        for (int pp = 0; pp < 4; pp++)
          for (int nx = 0; nx < 2; nx++) begin
            fill((t == 2) ? 1 : 0, 0, 1, 20'h00B01, p0w(24'h2222, 6'h11), 32'h0007_7180 | 32'(pp));
            look(32'h00B0_1000, 2'(t), 1'(k), 1'(nx), mt, "R4");
          end

    // R2 / R3 candidate rules
    mt = p0w(24'h3333, 6'h05) & 32'h7FFF_FFBF;
    fill(0, 0, 2, 20'h00C02, p0w(24'h3333, 6'h05), 32'h0001_2182);
    look(32'h00C0_2000, 2'd0, 1'b0, 1'b0, mt, "R2");
    look(32'h01C0_2000, 2'd0, 1'b0, 1'b0, mt, "R2");
    look(32'h00C0_2000, 2'd2, 1'b0, 1'b0, mt, "R1");
    look(32'h00C0_2000, 2'd0, 1'b0, 1'b0, mt ^ 32'h80, "R3");
    look(32'h00C0_2000, 2'd0, 1'b0, 1'b0, mt ^ 32'h1, "R3");
    fill(0, 0, 2, 20'h00C02, p0w(24'h3333, 6'h05) | 32'h40, 32'h0001_2182);
    look(32'h00C0_2000, 2'd0, 1'b0, 1'b0, mt, "R2");
    fill(0, 0, 2, 20'h00C02, p0w(24'h3333, 6'h05) & 32'h7FFF_FFFF, 32'h0001_2182);
    look(32'h00C0_2000, 2'd0, 1'b0, 1'b0, mt, "R2");

    // R5 / R6 way ordering
    mt = p0w(24'h4444, 6'h09) & 32'h7FFF_FFBF;
    fill(0, 0, 3, 20'h00D03, p0w(24'h4444, 6'h09), 32'h0003_3182);
    fill(0, 1, 3, 20'h00D03, p0w(24'h4444, 6'h09), 32'h0003_3186);
    look(32'h00D0_3000, 2'd0, 1'b0, 1'b0, mt, "R5");
    fill(0, 0, 3, 20'h00D03, p0w(24'h4444, 6'h09), 32'h0003_3180);
    fill(0, 1, 3, 20'h00D03, p0w(24'h4444, 6'h09), 32'h0003_3E84);
    look(32'h00D0_3000, 2'd0, 1'b1, 1'b0, mt, "R5");
    look(32'h00D0_3000, 2'd0, 1'b1, 1'b0, mt, "R7");
    fill(0, 0, 3, 20'h00D03, p0w(24'h4444, 6'h09), 32'h0003_3180);
    fill(0, 1, 3, 20'h00D03, p0w(24'h4444, 6'h09), 32'h0004_4182);
    look(32'h00D0_3000, 2'd0, 1'b1, 1'b0, mt, "R6");
    fill(0, 0, 3, 20'h00D03, p0w(24'h4444, 6'h09), 32'h0003_3182);
    look(32'h00D0_3000, 2'd0, 1'b0, 1'b0, mt, "R5");
    fill(0, 0, 3, 20'h00D03, p0w(24'h4444, 6'h09) | 32'h40, 32'h0003_3182);
    look(32'h00D0_3000, 2'd0, 1'b0, 1'b0, mt, "R5");

    // R7 / R8 referenced and changed flags
    mt = p0w(24'h5555, 6'h01) & 32'h7FFF_FFBF;
    fill(0, 1, 0, 20'h00000, 32'h0, 32'h0);
    fill(0, 0, 0, 20'h00E00, p0w(24'h5555, 6'h01), 32'h0006_6002);
    look(32'h00E0_0000, 2'd0, 1'b0, 1'b0, mt, "R8");
    look(32'h00E0_0000, 2'd0, 1'b0, 1'b0, mt, "R7");
    look(32'h00E0_0000, 2'd1, 1'b0, 1'b0, mt, "R8");
    look(32'h00E0_0000, 2'd0, 1'b0, 1'b0, mt, "R8");
    fill(0, 0, 0, 20'h00E00, p0w(24'h5555, 6'h01), 32'h0006_6003);
    look(32'h00E0_0000, 2'd1, 1'b1, 1'b0, mt, "R8");
    look(32'h00E0_0000, 2'd0, 1'b1, 1'b0, mt, "R8");

    // R10 fill wins over a request in the same cycle
    @(negedge clk);
    fill_en = 1'b1; fill_idx = 4'(slot(1, 1, 0)); fill_epn = 20'h00F00;
    fill_pte0 = p0w(24'h6666, 6'h02); fill_pte1 = 32'h0007_7182;
    req_valid = 1'b1; req_addr = 32'h00E0_0000; req_type = 2'd0; req_key = 1'b0;
    req_nx = 1'b0; req_match = mt;
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    m_epn[slot(1, 1, 0)] = 20'h00F00; m_p0[slot(1, 1, 0)] = p0w(24'h6666, 6'h02);
    m_p1[slot(1, 1, 0)] = 32'h0007_7182;
    chk("R10", "no response with fill", 32'(rsp_valid), 32'd0);
    chk("R10", "no busy with fill", 32'(busy), 32'd0);
    look(32'h00F0_0000, 2'd2, 1'b0, 1'b0, p0w(24'h6666, 6'h02) & 32'h7FFF_FFBF, "R10");

    // R9 request held through the busy cycle
    begin
      logic [1:0] st;
      logic [2:0] pm;
      logic [31:0] pw;
      predict(32'h00E0_0000, 2'd0, 1'b0, 1'b0, mt, st, pm, pw);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h00E0_0000; req_type = 2'd0;
      req_key = 1'b0; req_nx = 1'b0; req_match = mt;
      @(negedge clk);
      chk("R9", "first response", 32'(rsp_valid), 32'd1);
      chk("R9", "first status", 32'(rsp_status), 32'(st));
      chk("R9", "busy after hit", 32'(busy), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "request during busy dropped", 32'(rsp_valid), 32'd0);
      chk("R9", "busy single cycle", 32'(busy), 32'd0);
    end
    look(32'h00E0_0000, 2'd0, 1'b0, 1'b0, mt, "R7");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule